// File: doc/BRIEF.md
# Double-Edge DMA Burst Receiver

This block is the device-side receive path for the high-speed DMA write burst of a parallel disk interface. The host moves 16-bit words by toggling a data strobe. Every transition of that strobe carries one word, whether the level rises or falls. The receiver runs on a local system clock. It passes the strobe, the stop line and the data bus through a flop synchroniser. It detects strobe transitions by comparing successive synchronised samples and writes each captured word into a small first-in first-out buffer.

A burst opens only when the host has the handshake in a legal state. Once open, the receiver holds a ready line high while the buffer has spare room, and drops it early so that words already on the way still fit. The host ends the burst by raising its stop line. The receiver then closes the burst, pulses a done flag for one clock and holds the number of words the burst delivered. Downstream logic drains the buffer through a show-ahead pop port.

Top module: `dma_burst_rx`

## Requirements
- R1: After reset, `dev_ready_o`, `burst_active_o` and `burst_done_o` are 0, `fifo_empty_o` is 1, and `fifo_level_o` and `word_count_o` are 0.
- R2: A burst opens (`burst_active_o` goes to 1 one clock later) only when all of these hold: `dma_ack_i` is 1, `cs_n_i` is 2'b11, `host_wr_i` is 0, and the synchronised stop line is 0. If `cs_n_i` is not 2'b11 or `host_wr_i` is 1, no burst opens.
- R3: During an open burst with `dma_ack_i` at 1, each rising transition and each falling transition of `host_strobe_i` stores exactly one word taken from `data_i`. Words leave the buffer in the order they arrived.
- R4: A gap of any length with no strobe transitions stores no word and loses none. The capture count continues from its previous value when transitions resume.
- R5: `dev_ready_o` is 1 exactly when a burst is open and the buffer has more than READY_MARGIN (default 2) free entries out of DEPTH (default 8).
- R6: When stop is asserted during an open burst, the burst closes, `burst_done_o` is 1 for exactly one clock, and `word_count_o` holds the number of words the burst stored.
- R7: Strobe transitions that occur while `dma_ack_i` is 0 store nothing, even inside an open burst.
- R8: Strobe transitions that occur while no burst is open store nothing.
- R9: While `fifo_empty_o` is 0, `pop_data_o` shows the oldest stored word. A clock with `pop_i` at 1 removes that word. A pop while the buffer is empty has no effect.
- R10: `word_count_o` returns to 0 when a new burst opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_strobe_i | input | 1 | Host data strobe; asynchronous; each transition carries a word |
| host_stop_i | input | 1 | Host stop line; asynchronous; 1 ends the burst |
| dma_ack_i | input | 1 | DMA acknowledge from host, active high |
| cs_n_i | input | 2 | Host chip selects, active low |
| host_wr_i | input | 1 | Host register write strobe, 1 while asserted |
| data_i | input | DATA_W | Host data bus |
| pop_i | input | 1 | Remove the oldest buffered word |
| dev_ready_o | output | 1 | Device ready to receive; 0 pauses the host |
| burst_active_o | output | 1 | Burst is open |
| burst_done_o | output | 1 | One-clock pulse when a burst closes |
| word_count_o | output | CNT_W | Words stored in the current or last burst |
| pop_data_o | output | DATA_W | Oldest buffered word |
| fifo_empty_o | output | 1 | Buffer holds no word |
| fifo_level_o | output | LVL_W | Number of buffered words |

## Verification
The assertions rely on the host honouring the flow control. The host must stop producing strobe transitions within READY_MARGIN words after `dev_ready_o` falls; otherwise the overflow check fires. The assertions also take the data bus to be stable for at least the synchroniser depth around each transition, and stop to be raised only between words. The stimulus changes the strobe, the data and the control inputs only on the falling clock edge. Between transitions it waits several clocks. It never sends more words than the buffer can hold while ready is low, and it drops acknowledge before releasing stop so that a closed burst does not reopen.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  // free entries left in a buffer of the given depth
  function automatic int unsigned free_slots(input int unsigned depth,
                                             input int unsigned level);
    return (level >= depth) ? 0 : depth - level;
  endfunction

  // ready is granted only while more than margin entries stay free
  function automatic logic may_accept(input int unsigned free,
                                      input int unsigned margin);
    return free > margin;
  endfunction

  // next value of the capture counter
  function automatic int unsigned count_next(input int unsigned cur,
                                             input logic clear,
                                             input logic inc);
    if (clear) return 0;
    return inc ? cur + 1 : cur;
  endfunction

endpackage

// File: rtl/dbr_sync.sv
module dbr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbr_edge_capture.sv
module dbr_edge_capture #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              edge_o,
  output logic [DATA_W-1:0] word_o
);
  logic strobe_s;
  logic strobe_prev_q;

  // strobe and data share one synchroniser depth so they stay aligned
  dbr_sync #(.W(1), .STAGES(SYNC_STAGES)) u_strobe_sync (
    .clk(clk), .rst_n(rst_n), .d(strobe_i), .q(strobe_s)
  );

  dbr_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .d(data_i), .q(word_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_prev_q <= 1'b0;
    else        strobe_prev_q <= strobe_s;
  end

  // one pulse per level change, rising or falling
  assign edge_o = strobe_s ^ strobe_prev_q;

  // a pulse is followed by a steady sample unless the strobe moves again
  AST_EDGE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (strobe_prev_q != $past(strobe_prev_q))); // R3
endmodule

// File: rtl/dbr_rx_fifo.sv
module dbr_rx_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              empty_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  level_q;
  logic              do_push, do_pop;

  assign empty_o = (level_q == '0);
  assign do_push = push_i && (int'(level_q) < DEPTH);
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign pop_data_o = mem_q[rd_ptr_q];
  assign level_o    = level_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (int'(level_q) < DEPTH)); // R5
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_q) <= DEPTH); // R3
  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !push_i) |=> empty_o); // R9
endmodule

// File: rtl/dbr_burst_ctrl.sv
module dbr_burst_ctrl
  import dbr_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int CNT_W        = 16,
  parameter int READY_MARGIN = 2,
  localparam int LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_i,
  input  logic [1:0]       cs_n_i,
  input  logic             wr_i,
  input  logic             stop_s_i,
  input  logic             edge_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             active_o,
  output logic             capture_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ready_o
);
  logic             active_q, done_q;
  logic [CNT_W-1:0] count_q;
  logic             start_ok, end_ev;

  assign start_ok  = !active_q && ack_i && (cs_n_i == 2'b11) && !wr_i && !stop_s_i;
  assign end_ev    = active_q && stop_s_i;
  assign capture_o = active_q && ack_i && edge_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      count_q  <= '0;
    end else begin
      if (start_ok)    active_q <= 1'b1;
      else if (end_ev) active_q <= 1'b0;
      done_q  <= end_ev;
      count_q <= CNT_W'(count_next(int'(count_q), start_ok, capture_o));
    end
  end

  assign ready_o  = active_q &&
                    may_accept(free_slots(DEPTH, int'(level_i)), READY_MARGIN);
  assign active_o = active_q;
  assign done_o   = done_q;
  assign count_o  = count_q;

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> ($past(ack_i) && ($past(cs_n_i) == 2'b11) && !$past(wr_i))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_DONE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !active_q); // R6
  AST_NO_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !ack_i && !start_ok) |=> $stable(count_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start_ok) |=> $stable(count_q)); // R8
endmodule

// File: rtl/dma_burst_rx.sv
module dma_burst_rx #(
  parameter int DATA_W       = 16,
  parameter int DEPTH        = 8,
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int READY_MARGIN = 2,
  localparam int LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_strobe_i,
  input  logic              host_stop_i,
  input  logic              dma_ack_i,
  input  logic [1:0]        cs_n_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              dev_ready_o,
  output logic              burst_active_o,
  output logic              burst_done_o,
  output logic [CNT_W-1:0]  word_count_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              fifo_empty_o,
  output logic [LVL_W-1:0]  fifo_level_o
);
  // internal events as named wires
  logic              stop_sync;
  logic              strobe_edge;
  logic [DATA_W-1:0] strobe_word;
  logic              capture_ev;
  logic [LVL_W-1:0]  level_w;

  dbr_sync #(.W(1), .STAGES(SYNC_STAGES)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .d(host_stop_i), .q(stop_sync)
  );

  dbr_edge_capture #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk(clk), .rst_n(rst_n), .strobe_i(host_strobe_i), .data_i(data_i),
    .edge_o(strobe_edge), .word_o(strobe_word)
  );

  dbr_burst_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .READY_MARGIN(READY_MARGIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ack_i(dma_ack_i), .cs_n_i(cs_n_i), .wr_i(host_wr_i),
    .stop_s_i(stop_sync), .edge_i(strobe_edge), .level_i(level_w),
    .active_o(burst_active_o), .capture_o(capture_ev), .done_o(burst_done_o),
    .count_o(word_count_o), .ready_o(dev_ready_o)
  );

  dbr_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(capture_ev), .push_data_i(strobe_word),
    .pop_i(pop_i), .pop_data_o(pop_data_o), .empty_o(fifo_empty_o), .level_o(level_w)
  );

  assign fifo_level_o = level_w;

  AST_READY_MARGIN: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ready_o |-> ((DEPTH - int'(fifo_level_o)) > READY_MARGIN)); // R5
  AST_READY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active_o |-> !dev_ready_o); // R5
  AST_CAPTURE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_ev && !pop_i) |=> !fifo_empty_o); // R3
endmodule

// File: tb/test_dma_burst_rx.sv
module test_dma_burst_rx;
  localparam int DEPTH  = 8;
  localparam int MARGIN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0, stop = 1'b0, ack = 1'b0, wr = 1'b0, pop = 1'b0;
  logic [1:0]  cs_n = 2'b11;
  logic [15:0] data = '0;
  logic        ready, active, done, empty;
  logic [15:0] wcount, pdata;
  logic [3:0]  level;

  int checks = 0, errors = 0, done_seen = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_burst_rx i_dma_burst_rx (
    .clk(clk), .rst_n(rst_n), .host_strobe_i(strobe), .host_stop_i(stop),
    .dma_ack_i(ack), .cs_n_i(cs_n), .host_wr_i(wr), .data_i(data), .pop_i(pop),
    .dev_ready_o(ready), .burst_active_o(active), .burst_done_o(done),
    .word_count_o(wcount), .pop_data_o(pdata), .fifo_empty_o(empty),
    .fifo_level_o(level)
  );

  always @(posedge clk) if (done) done_seen++;

  localparam logic [15:0] VEC [10] = '{
    16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h0001,
    16'h8000, 16'h1234, 16'hFEDC, 16'h00FF, 16'hFF00
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    data   = w;
    strobe = ~strobe;
    tick(5);
  endtask

  task automatic pop_one;
    pop = 1'b1;
    tick(1);
    pop = 1'b0;
  endtask

  task automatic open_burst;
    ack = 1'b1; cs_n = 2'b11; wr = 1'b0;
    tick(2);
  endtask

  task automatic close_burst;
    stop = 1'b1;
    tick(6);
    ack = 1'b0;
    stop = 1'b0;
    tick(4);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int d0;
    tick(3);
    // R1 reset state
    chk("R1 ready", ready, 0);
    chk("R1 active", active, 0);
    chk("R1 empty", empty, 1);
    chk("R1 count", wcount, 0);
    rst_n = 1'b1;
    tick(3);
    chk("R1 done", done, 0);
    chk("R1 level", level, 0);

    // R8 transitions with no burst open
    send(16'h1111); send(16'h2222);
    chk("R8 idle level", level, 0);

    // R2 gating by chip selects and write strobe
    ack = 1'b1; cs_n = 2'b10; tick(4);
    chk("R2 cs blocks", active, 0);
    cs_n = 2'b11; wr = 1'b1; tick(4);
    chk("R2 wr blocks", active, 0);
    wr = 1'b0; tick(2);
    chk("R2 opens", active, 1);
    chk("R5 ready when open", ready, 1);

    // R3/R9 table walk: both transition directions, order kept
    for (int i = 0; i < 10; i++) begin
      send(VEC[i]);
      chk("R3 level", level, 1);
      chk("R9 head word", pdata, VEC[i]);
      pop_one();
    end
    chk("R3 word count", wcount, 10);

    // R9 pop while empty has no effect
    pop_one();
    chk("R9 empty pop", level, 0);

    // R4 long pause then resume
    tick(300);
    chk("R4 pause no store", level, 0);
    send(16'hBEEF);
    chk("R4 resume", wcount, 11);
    chk("R4 data kept", pdata, 16'hBEEF);
    pop_one();

    // R5 ready margin
    for (int i = 0; i < 5; i++) send(16'h0100 + 16'(i));
    chk("R5 ready at 5", ready, 1);
    send(16'h0105);
    chk("R5 ready low at 6", ready, 0);
    send(16'h0106);
    chk("R5 in-flight stored", level, 7);
    pop_one(); pop_one();
    chk("R5 ready back", ready, 1);
    for (int i = 2; i < 7; i++) begin
      chk("R3 order", pdata, 16'h0100 + 16'(i));
      pop_one();
    end

    // R7 acknowledge low gates capture
    ack = 1'b0; tick(2);
    send(16'h7777); send(16'h7778);
    chk("R7 no store", level, 0);
    chk("R7 still open", active, 1);
    ack = 1'b1; tick(2);

    // R6 stop closes burst
    d0 = done_seen;
    close_burst();
    chk("R6 single done", done_seen - d0, 1);
    chk("R6 closed", active, 0);
    chk("R6 total", wcount, 18);
    chk("R5 ready closed", ready, 0);

    // R10 new burst clears count
    open_burst();
    chk("R10 cleared", wcount, 0);
    send(16'hCAFE);
    chk("R10 counts", wcount, 1);
    pop_one();
    close_burst();

    finish_run();
  end
endmodule